// File: doc/BRIEF.md
# Serial Configuration Register Bank with Staged Commit

This block takes configuration words over a three-wire serial write port and spreads them across five configuration registers for a frequency synthesizer. The port has a shift clock, a data line and a load strobe. Each word is 24 bits long. Its top four bits select a register and the low twenty bits carry the payload. The serial pins are asynchronous to the system clock, so the block first synchronizes them and then detects their rising edges in the system clock domain.

The divider-ratio register takes effect as soon as it is written. Writes to the pump-current register and to the reference/prescaler register go into shadow buffers and stay there. Each write to the divider-ratio register copies the latest contents of both buffers to the active outputs, in the same cycle as the new divider values. Software can therefore retune the divider, the pump currents and the reference divider together in one transaction. The function register and the general-purpose output register update on their own writes. Each divider write also raises a one-cycle frequency-change pulse, which the fast-lock and lock-detect logic use. A configured flag rises once every register has been written at least once.

Top module: `serial_cfg_bank`

## Requirements
- R1: After reset, every register output is zero, and both freq_chg and configured are low.
- R2: Data bits are taken MSB first on each rising ser_clk while ser_le is low. A word is decoded on the rising edge of ser_le: bits 23:20 are the address and bits 19:0 are the payload. A frame with fewer than 24 ser_clk edges is discarded. A frame with more than 24 edges uses the last 24 bits shifted in.
- R3: A word to address 1 loads div_b from payload bits 18:6 and div_a from payload bits 5:0.
- R4: A word to address 2 stores pump_fast (payload bits 9:6) and pump_norm (payload bits 3:0) in a buffer. It leaves the active pump outputs unchanged.
- R5: A word to address 3 stores pre_sel (payload bits 15:14) and ref_div (payload bits 13:0) in a buffer. It leaves the active outputs unchanged.
- R6: A word to address 1 copies the most recent buffered contents of addresses 2 and 3 to the active outputs. This happens in the same cycle as the new divider values.
- R7: A word to address 4 updates these outputs at once:
  - lock_cnt_sel from payload bits 18:17
  - fast_en from bit 16
  - pump_tristate from bit 15
  - pump_invert from bit 14
  - lock_mode from bit 13
  - fast_count from bits 12:0
- R8: A word to address 5 updates the general-purpose outputs at once: gpo[0] comes from payload bit 0 and gpo[1] from payload bit 1.
- R9: freq_chg is high for exactly one system clock for each word to address 1, in the cycle the new divider values appear. Words to any other address produce no pulse.
- R10: A word to address 0 or to addresses 6 to 15 changes no output, produces no pulse and does not count toward configured.
- R11: configured goes high once each of addresses 1 to 5 has been written at least once, and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_data | input | 1 | Serial data, MSB first |
| ser_le | input | 1 | Load strobe; a word is decoded on its rising edge |
| div_b | output | 13 | Active main (B) counter value |
| div_a | output | 6 | Active swallow (A) counter value |
| pump_norm | output | 4 | Active normal pump-current code |
| pump_fast | output | 4 | Active fast-lock pump-current code |
| pre_sel | output | 2 | Active prescaler select |
| ref_div | output | 14 | Active reference divider value |
| lock_cnt_sel | output | 2 | Lock-detect count select |
| fast_en | output | 1 | Fast-lock enable |
| pump_tristate | output | 1 | Pump output high-impedance request |
| pump_invert | output | 1 | Pump polarity inversion |
| lock_mode | output | 1 | Lock-detect mode select |
| fast_count | output | 13 | Fast-lock duration count |
| gpo | output | 2 | General-purpose outputs |
| freq_chg | output | 1 | One-cycle pulse on each divider write |
| configured | output | 1 | All five registers written since reset |

## Verification
A corrupted shadow buffer stays hidden until the next divider write. At that point it appears on pump_norm, pump_fast, pre_sel or ref_div, in the same cycle as freq_chg. The bench therefore writes several buffered values before each commit and checks that only the last one arrives. A wrong bit counter or a wrong framing decision shows up after the next ser_le rise: either an output changes that should have stayed put, or an expected update is missing. It shows up within a few system clocks of that rise. A decode that hits an unused address, or a pulse that lasts too long, shows immediately in the count of freq_chg cycles and in the register outputs.

// File: rtl/cfg_bank_pkg.sv
// Shared constants and field types for the serial configuration register bank.
// Assumes a fixed 24-bit word with the address in the top four bits.
package cfg_bank_pkg;
    localparam int WORD_W   = 24;
    localparam int ADDR_W   = 4;
    localparam int DATA_W   = WORD_W - ADDR_W;
    localparam int NUM_REGS = 5;

    // Register selectors; the addresses are fixed by the write protocol.
    localparam logic [ADDR_W-1:0] ADR_DIV  = 4'd1;
    localparam logic [ADDR_W-1:0] ADR_PUMP = 4'd2;
    localparam logic [ADDR_W-1:0] ADR_REF  = 4'd3;
    localparam logic [ADDR_W-1:0] ADR_FUNC = 4'd4;
    localparam logic [ADDR_W-1:0] ADR_GPO  = 4'd5;

    typedef struct packed {
        logic [12:0] b;
        logic [5:0]  a;
    } div_t;

    typedef struct packed {
        logic [3:0] fast;
        logic [3:0] norm;
    } pump_t;

    typedef struct packed {
        logic [1:0]  pre;
        logic [13:0] rdiv;
    } ref_t;

    typedef struct packed {
        logic [1:0]  lock_sel;
        logic        fast_en;
        logic        tristate;
        logic        invert;
        logic        lock_mode;
        logic [12:0] fast_cnt;
    } func_t;
endpackage

// File: rtl/cfg_sync.sv
// Multi-stage synchronizer with rising-edge detect for asynchronous pins.
// Assumes each input stays at a level for longer than STAGES+1 system clocks.
module cfg_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] rise
);
    logic [STAGES-1:0][WIDTH-1:0] chain;
    logic [WIDTH-1:0]             prev;

    // First stage samples the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= async_in;
    end

    // Remaining stages shift the sampled value along.
    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
        end
    end

    // Keep the previous synchronized value for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= chain[STAGES-1];
    end

    assign level = chain[STAGES-1];
    assign rise  = chain[STAGES-1] & ~prev;
endmodule

// File: rtl/cfg_shifter.sv
// Serial word assembler. Shifts data MSB first on shift-clock rises while the
// strobe is low, and offers the word on the strobe rise when at least WORD_W
// bits arrived. Assumes synchronized, edge-detected inputs.
module cfg_shifter
    import cfg_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_rise,
    input  logic              le_rise,
    input  logic              le_level,
    input  logic              sdata,
    output logic              word_valid,
    output logic [WORD_W-1:0] word
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(WORD_W);

    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  cnt;

    // Shift, count with saturation, and hand over complete words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg      <= '0;
            cnt        <= '0;
            word       <= '0;
            word_valid <= 1'b0;
        end else begin
            word_valid <= 1'b0;
            if (le_rise) begin
                word_valid <= (cnt == FULL);
                word       <= shreg;
                cnt        <= '0;
            end else if (sclk_rise && !le_level) begin
                shreg <= {shreg[WORD_W-2:0], sdata};
                if (cnt != FULL) cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cfg_regs.sv
// Register file with address decode, shadow buffers for the pump and
// reference registers, commit on divider writes, and the configured flag.
// Assumes word_valid is a single-cycle strobe.
module cfg_regs
    import cfg_bank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word,
    output div_t              div_act,
    output pump_t             pump_act,
    output ref_t              ref_act,
    output func_t             func_act,
    output logic [1:0]        gpo_act,
    output logic              freq_chg,
    output logic              configured
);
    logic [ADDR_W-1:0]   addr;
    logic [DATA_W-1:0]   data;
    logic [NUM_REGS-1:0] hit;
    logic [NUM_REGS-1:0] written;
    pump_t               pump_sh;
    ref_t                ref_sh;

    assign addr = word[WORD_W-1 -: ADDR_W];
    assign data = word[DATA_W-1:0];

    // One-hot write decode; register k sits at address k+1.
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_hit
        assign hit[k] = word_valid && (addr == ADDR_W'(k + 1));
    end

    // Shadow buffers for the pump and reference registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pump_sh <= '0;
            ref_sh  <= '0;
        end else begin
            if (hit[ADR_PUMP-1]) pump_sh <= '{fast: data[9:6], norm: data[3:0]};
            if (hit[ADR_REF-1])  ref_sh  <= '{pre: data[15:14], rdiv: data[13:0]};
        end
    end

    // A divider write commits the divider and both buffers together.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_act  <= '0;
            pump_act <= '0;
            ref_act  <= '0;
            freq_chg <= 1'b0;
        end else begin
            freq_chg <= hit[ADR_DIV-1];
            if (hit[ADR_DIV-1]) begin
                div_act  <= '{b: data[18:6], a: data[5:0]};
                pump_act <= pump_sh;
                ref_act  <= ref_sh;
            end
        end
    end

    // Function and general-purpose registers take effect on their own write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            func_act <= '0;
            gpo_act  <= '0;
        end else begin
            if (hit[ADR_FUNC-1]) func_act <= func_t'(data[18:0]);
            if (hit[ADR_GPO-1])  gpo_act  <= data[1:0];
        end
    end

    // Remember which registers have been written since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) written <= '0;
        else        written <= written | hit;
    end

    assign configured = &written;
endmodule

// File: rtl/serial_cfg_bank.sv
// Top level of the serial configuration bank: pin synchronizer, word
// assembler and register file. Assumes the serial pins are asynchronous and
// change slowly compared with the system clock.
module serial_cfg_bank
    import cfg_bank_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ser_clk,
    input  logic        ser_data,
    input  logic        ser_le,
    output logic [12:0] div_b,
    output logic [5:0]  div_a,
    output logic [3:0]  pump_norm,
    output logic [3:0]  pump_fast,
    output logic [1:0]  pre_sel,
    output logic [13:0] ref_div,
    output logic [1:0]  lock_cnt_sel,
    output logic        fast_en,
    output logic        pump_tristate,
    output logic        pump_invert,
    output logic        lock_mode,
    output logic [12:0] fast_count,
    output logic [1:0]  gpo,
    output logic        freq_chg,
    output logic        configured
);
    logic [2:0]        pin_level;
    logic [2:0]        pin_rise;
    logic              word_valid;
    logic [WORD_W-1:0] word;
    div_t              div_act;
    pump_t             pump_act;
    ref_t              ref_act;
    func_t             func_act;

    cfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({ser_le, ser_data, ser_clk}),
        .level    (pin_level),
        .rise     (pin_rise)
    );

    cfg_shifter u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_rise  (pin_rise[0]),
        .le_rise    (pin_rise[2]),
        .le_level   (pin_level[2]),
        .sdata      (pin_level[1]),
        .word_valid (word_valid),
        .word       (word)
    );

    cfg_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_valid (word_valid),
        .word       (word),
        .div_act    (div_act),
        .pump_act   (pump_act),
        .ref_act    (ref_act),
        .func_act   (func_act),
        .gpo_act    (gpo),
        .freq_chg   (freq_chg),
        .configured (configured)
    );

    assign div_b         = div_act.b;
    assign div_a         = div_act.a;
    assign pump_norm     = pump_act.norm;
    assign pump_fast     = pump_act.fast;
    assign pre_sel       = ref_act.pre;
    assign ref_div       = ref_act.rdiv;
    assign lock_cnt_sel  = func_act.lock_sel;
    assign fast_en       = func_act.fast_en;
    assign pump_tristate = func_act.tristate;
    assign pump_invert   = func_act.invert;
    assign lock_mode     = func_act.lock_mode;
    assign fast_count    = func_act.fast_cnt;
endmodule

// File: rtl/serial_cfg_bank_chk.sv
// Property checker for the serial configuration bank, bound to the top level.
// Assumes it sees the assembled-word strobe from inside the top.
module serial_cfg_bank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        word_valid,
    input logic [12:0] div_b,
    input logic [5:0]  div_a,
    input logic [3:0]  pump_norm,
    input logic [3:0]  pump_fast,
    input logic [1:0]  pre_sel,
    input logic [13:0] ref_div,
    input logic [18:0] func_bits,
    input logic [1:0]  gpo,
    input logic        freq_chg,
    input logic        configured
);
    assert_pulse_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        freq_chg |=> !freq_chg);

    assert_pulse_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        freq_chg |-> $past(word_valid));

    assert_div_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !freq_chg |-> ($stable(div_b) && $stable(div_a)));

    assert_pump_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !freq_chg |-> ($stable(pump_norm) && $stable(pump_fast)));

    assert_ref_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !freq_chg |-> ($stable(pre_sel) && $stable(ref_div)));

    assert_func_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(func_bits) |-> $past(word_valid));

    assert_gpo_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(gpo) |-> $past(word_valid));

    assert_cfg_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        configured |=> configured);
endmodule

bind serial_cfg_bank serial_cfg_bank_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .word_valid (word_valid),
    .div_b      (div_b),
    .div_a      (div_a),
    .pump_norm  (pump_norm),
    .pump_fast  (pump_fast),
    .pre_sel    (pre_sel),
    .ref_div    (ref_div),
    .func_bits  ({lock_cnt_sel, fast_en, pump_tristate, pump_invert, lock_mode, fast_count}),
    .gpo        (gpo),
    .freq_chg   (freq_chg),
    .configured (configured)
);

// File: tb/tb_serial_cfg_bank.sv
module tb_serial_cfg_bank;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0;
    logic ser_data = 1'b0;
    logic ser_le = 1'b1;
    logic [12:0] div_b;
    logic [5:0]  div_a;
    logic [3:0]  pump_norm, pump_fast;
    logic [1:0]  pre_sel;
    logic [13:0] ref_div;
    logic [1:0]  lock_cnt_sel;
    logic        fast_en, pump_tristate, pump_invert, lock_mode;
    logic [12:0] fast_count;
    logic [1:0]  gpo;
    logic        freq_chg, configured;

    always #5 clk = ~clk;

    serial_cfg_bank dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data), .ser_le(ser_le),
        .div_b(div_b), .div_a(div_a), .pump_norm(pump_norm), .pump_fast(pump_fast),
        .pre_sel(pre_sel), .ref_div(ref_div), .lock_cnt_sel(lock_cnt_sel), .fast_en(fast_en),
        .pump_tristate(pump_tristate), .pump_invert(pump_invert), .lock_mode(lock_mode),
        .fast_count(fast_count), .gpo(gpo), .freq_chg(freq_chg), .configured(configured)
    );

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int pulse_cnt = 0;
    int exp_pulses = 0;

    // Expected state, derived from the field positions in the requirements.
    logic [12:0] m_b;    logic [5:0] m_a;
    logic [3:0]  m_cpn, m_cpf, s_cpn, s_cpf;
    logic [1:0]  m_pre, s_pre;
    logic [13:0] m_ref, s_ref;
    logic [18:0] m_func;
    logic [1:0]  m_gpo;
    logic [4:0]  m_wr;

    localparam int NV = 14;
    localparam logic [23:0] VEC [NV] = '{
        24'h200243, 24'h38ABCD, 24'h14C1D4, 24'h47FFFF, 24'h500002,
        24'h0FFFFF, 24'hF12345, 24'h2FFFFF, 24'h100005, 24'h400000,
        24'h500003, 24'h30ABCD, 24'h3C0004, 24'h17FFFF
    };

    // Count every cycle freq_chg is high.
    always @(negedge clk) if (rst_n && freq_chg) pulse_cnt++;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_reset();
        m_b = '0; m_a = '0; m_cpn = '0; m_cpf = '0; s_cpn = '0; s_cpf = '0;
        m_pre = '0; s_pre = '0; m_ref = '0; s_ref = '0; m_func = '0; m_gpo = '0; m_wr = '0;
    endtask

    task automatic model_apply(input logic [23:0] w);
        logic [19:0] d;
        d = w[19:0];
        case (w[23:20])
            4'd1: begin
                m_b = d[18:6]; m_a = d[5:0];
                m_cpn = s_cpn; m_cpf = s_cpf; m_pre = s_pre; m_ref = s_ref;
                exp_pulses++; m_wr[0] = 1'b1;
            end
            4'd2: begin s_cpf = d[9:6]; s_cpn = d[3:0]; m_wr[1] = 1'b1; end
            4'd3: begin s_pre = d[15:14]; s_ref = d[13:0]; m_wr[2] = 1'b1; end
            4'd4: begin m_func = d[18:0]; m_wr[3] = 1'b1; end
            4'd5: begin m_gpo = d[1:0]; m_wr[4] = 1'b1; end
            default: ;
        endcase
    endtask

    task automatic check_all(input string tag);
        chk({tag, " R3 div_b"}, 32'(div_b), 32'(m_b));
        chk({tag, " R3 div_a"}, 32'(div_a), 32'(m_a));
        chk({tag, " R4 pump_norm"}, 32'(pump_norm), 32'(m_cpn));
        chk({tag, " R4 pump_fast"}, 32'(pump_fast), 32'(m_cpf));
        chk({tag, " R5 pre_sel"}, 32'(pre_sel), 32'(m_pre));
        chk({tag, " R5 ref_div"}, 32'(ref_div), 32'(m_ref));
        chk({tag, " R7 func"}, 32'({lock_cnt_sel, fast_en, pump_tristate, pump_invert,
                                     lock_mode, fast_count}), 32'(m_func));
        chk({tag, " R8 gpo"}, 32'(gpo), 32'(m_gpo));
        chk({tag, " R9 pulses"}, 32'(pulse_cnt), 32'(exp_pulses));
        chk({tag, " R11 configured"}, 32'(configured), 32'(&m_wr));
    endtask

    // Send the low n bits of w, MSB first, then raise the strobe.
    task automatic send(input logic [31:0] w, input int n);
        @(negedge clk); ser_le = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            ser_data = w[i];
            repeat (4) @(negedge clk);
            ser_clk = 1'b1;
            repeat (4) @(negedge clk);
            ser_clk = 1'b0;
        end
        repeat (4) @(negedge clk);
        ser_le = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        // R1: reset state
        check_all("R1 reset");
        chk("R1 freq_chg low", 32'(freq_chg), 32'd0);

        // Table walk: R4 R5 buffering, R6 commit with latest buffers, R10 ignored.
        for (int v = 0; v < NV; v++) begin
            send(32'(VEC[v]), 24);
            model_apply(VEC[v]);
            check_all($sformatf("R2 R6 R10 vec%0d", v));
        end

        // R2: short frame of 20 clocks is discarded.
        send(32'h500000, 20);
        check_all("R2 short frame");
        chk("R2 short gpo", 32'(gpo), 32'd3);

        // R2: long frame keeps the last 24 bits (address 5, gpo=1).
        send(32'hA500001, 28);
        model_apply(24'h500001);
        check_all("R2 long frame");
        chk("R2 long gpo", 32'(gpo), 32'd1);

        // R10: unused address with a full payload changes nothing.
        send(32'hE7FFFF, 24);
        check_all("R10 addr 14");

        // R1 R11: reset clears everything including the configured flag.
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset();
        repeat (8) @(negedge clk);
        check_all("R1 second reset");

        // R11: four of five registers written, configured stays low.
        send(32'h200001, 24); model_apply(24'h200001);
        send(32'h300004, 24); model_apply(24'h300004);
        send(32'h400001, 24); model_apply(24'h400001);
        send(32'h500001, 24); model_apply(24'h500001);
        check_all("R11 partial");
        chk("R11 not yet configured", 32'(configured), 32'd0);
        send(32'h1000C3, 24); model_apply(24'h1000C3);
        check_all("R11 full");
        chk("R11 configured", 32'(configured), 32'd1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule